// File: doc/BRIEF.md
# Serial Receiver with Tagged Character Queue

This block is the receive half of an asynchronous serial port that sits behind a byte-wide CPU register interface. A 16x oversampling deserializer checks each start bit at its midpoint. It then assembles eight data bits, least significant first, an optional parity bit and a stop bit. Each finished character is handed to a queue together with three one-bit tags: parity error, framing error and break. The tags move through the queue with their character, so the status the CPU sees always describes the character it is about to read.

The CPU reads characters through a data strobe that pops the head entry. It reads the line status byte through a status strobe. The status byte shows data-ready, overrun, the three head-of-queue tags and a summary bit that stays set while any queued character carries a tag. A mode input chooses between a 16-deep queue and a single holding register. When storage is full, a newly completed character is dropped and the stored ones are kept. A long break produces exactly one queue entry. Bit timing comes from an external sample-enable pulse at 16 times the bit rate.

Top module: `serial_rx_tagq`

## Requirements
- R1: After reset the line status byte is 0x00 and the data output is 0x00.
- R2: A frame is a low start bit, 8 data bits sent LSB first, an optional parity bit and a high stop bit, 16 sample pulses per bit. Status bit 0 is 1 while at least one character is stored. Pulsing the data strobe presents and removes the oldest character.
- R3: With queue mode on (`queue_mode`=1), up to 16 characters are held and read back in arrival order.
- R4: A character that completes while storage is full is discarded, and stored characters stay unchanged. The discard sets status bit 1, and a status strobe clears it. If a discard and a status strobe fall in the same cycle, the bit is left set.
- R5: With `par_en`=1, the parity bit must equal the XOR of the data bits when `par_odd`=0, and its inverse when `par_odd`=1. A mismatch tags the character, and status bit 2 shows the tag of the head character.
- R6: A low stop bit in a frame that is not all-low tags a framing error, and status bit 3 shows the tag of the head character.
- R7: A frame in which every sampled bit, stop bit included, is low is stored as one break entry: data 0x00, break tag 1, other tags 0. Status bit 4 shows the tag of the head character. The receiver accepts no new start bit until the line has returned high, so a break of any length gives one entry.
- R8: Status bit 7 is 1 while any stored character carries a parity, framing or break tag, and 0 once none remain.
- R9: With `queue_mode`=0, storage is a single holding register, so a second character arriving before the first is read is discarded under R4.
- R10: A low pulse shorter than half a bit time is not accepted as a start bit, and nothing is stored.
- R11: A data strobe while storage is empty has no effect, and status bits 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| queue_mode | input | 1 | 1 selects the 16-deep queue, 0 the single holding register |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| data_rd | input | 1 | Pops the head character |
| stat_rd | input | 1 | Status read, clears the overrun bit |
| rd_data | output | 8 | Head character data, 0 when empty |
| line_stat | output | 8 | Line status byte |

## Verification
The case that needs care is a discard from a full queue arriving in the same cycle as a status read. In that cycle one event sets the overrun bit and the other clears it. The bench fills the queue and then sends one more character. While that character is received, it raises the status strobe on every cycle, and drops it on the first cycle the overrun bit is seen high. If the clear won, the bit would never be seen high and the check fails. If the set wins, the bit stays high after the strobe is released.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int unsigned CHAR_BITS = 8;

  typedef struct packed {
    logic                 brk;
    logic                 ferr;
    logic                 perr;
    logic [CHAR_BITS-1:0] data;
  } srx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } srx_state_t;

endpackage

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_raw,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output srx_entry_t ent
);

  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned BW  = $clog2(CHAR_BITS);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOPB = BW'(CHAR_BITS - 1);

  logic                 sync1_q, sync2_q;
  srx_state_t           state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [CHAR_BITS-1:0] sh_q, sh_d;
  logic                 par_q, par_d;
  logic                 allz_q, allz_d;
  logic                 done_q, done_d;
  srx_entry_t           ent_q, ent_d;
  logic                 rx_s;
  logic                 at_last;

  assign rx_s    = sync2_q;
  assign at_last = tick && (cnt_q == LAST);

  // input synchronizer, idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rx_raw;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    par_d   = par_q;
    allz_d  = allz_q;
    done_d  = 1'b0;
    ent_d   = ent_q;
    if (tick && state_q != ST_IDLE && state_q != ST_HOLD) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
    unique case (state_q)
      ST_IDLE: begin
        if (tick && !rx_s) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (tick && cnt_q == MID) begin
          cnt_d  = '0;
          bit_d  = '0;
          allz_d = 1'b1;
          state_d = rx_s ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (at_last) begin
          sh_d   = {rx_s, sh_q[CHAR_BITS-1:1]};
          allz_d = allz_q & ~rx_s;
          if (bit_q == TOPB) begin
            state_d = par_en ? ST_PAR : ST_STOP;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (at_last) begin
          par_d   = rx_s;
          allz_d  = allz_q & ~rx_s;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (at_last) begin
          done_d = 1'b1;
          if (allz_q && !rx_s) begin
            ent_d = '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
          end else begin
            ent_d.brk  = 1'b0;
            ent_d.ferr = ~rx_s;
            ent_d.perr = par_en & (par_q != ((^sh_q) ^ par_odd));
            ent_d.data = sh_q;
          end
          state_d = rx_s ? ST_IDLE : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tick && rx_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      allz_q  <= 1'b0;
      done_q  <= 1'b0;
      ent_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      allz_q  <= allz_d;
      done_q  <= done_d;
      ent_q   <= ent_d;
    end
  end

  assign done = done_q;
  assign ent  = ent_q;

  // R2: a completed character is reported for exactly one cycle
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: after a break entry the receiver waits for the line to go high
  a_r7_hold_after_break: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ent_q.brk) |-> (state_q == ST_HOLD));

  // R10: a start that fails mid-bit validation never yields a character
  a_r10_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && state_d == ST_IDLE) |=> !done_q);

endmodule

// File: rtl/srx_tagq.sv
module srx_tagq
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       queue_mode,
  input  logic       push,
  input  srx_entry_t push_ent,
  input  logic       pop_req,
  output srx_entry_t head,
  output logic       empty,
  output logic       tagged_any,
  output logic       ovr_evt
);

  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] CAP_Q = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] CAP_H = CNTW'(1);
  localparam logic [AW-1:0]   TOPP  = AW'(DEPTH - 1);

  srx_entry_t      mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d, wr_inc, rd_inc;
  logic [CNTW-1:0] cnt_q, cnt_d, tag_q, tag_d, cap;
  logic            full, push_ok, pop_ok, in_tag, head_tag;

  // pointer advance: free wrap for power-of-two depths, compare otherwise
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_inc = wr_q + 1'b1;
      assign rd_inc = rd_q + 1'b1;
    end else begin : g_mod
      assign wr_inc = (wr_q == TOPP) ? '0 : wr_q + 1'b1;
      assign rd_inc = (rd_q == TOPP) ? '0 : rd_q + 1'b1;
    end
  endgenerate

  assign cap      = queue_mode ? CAP_Q : CAP_H;
  assign full     = (cnt_q >= cap);
  assign pop_ok   = pop_req && (cnt_q != '0);
  assign push_ok  = push && (!full || pop_ok);
  assign ovr_evt  = push && !push_ok;
  assign head     = mem[rd_q];
  assign in_tag   = push_ent.brk | push_ent.ferr | push_ent.perr;
  assign head_tag = head.brk | head.ferr | head.perr;

  always_comb begin
    wr_d  = push_ok ? wr_inc : wr_q;
    rd_d  = pop_ok  ? rd_inc : rd_q;
    cnt_d = cnt_q;
    tag_d = tag_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
    if ((push_ok && in_tag) && !(pop_ok && head_tag)) tag_d = tag_q + 1'b1;
    if (!(push_ok && in_tag) && (pop_ok && head_tag)) tag_d = tag_q - 1'b1;
  end

  // storage carries no reset; it is only looked at while occupied
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      tag_q <= tag_d;
    end
  end

  assign empty      = (cnt_q == '0);
  assign tagged_any = (tag_q != '0);

  // R3: occupancy never exceeds the queue depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP_Q);

  // R4: a discarded character leaves the stored ones alone
  a_r4_keep_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !pop_req) |=> (cnt_q == $past(cnt_q) && wr_q == $past(wr_q)));

  // R8: tagged entries are a subset of stored entries
  a_r8_tag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tag_q <= cnt_q);

  // R9: holding-register mode never takes a second character
  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_mode && cnt_q == CAP_H && push && !pop_req) |-> ovr_evt);

  // R11: popping an empty store changes nothing
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && !push) |=> (cnt_q == '0 && rd_q == $past(rd_q)));

endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_evt,
  input  logic       stat_rd,
  input  logic       empty,
  input  logic       head_perr,
  input  logic       head_ferr,
  input  logic       head_brk,
  input  logic       tagged_any,
  output logic [7:0] stat
);

  logic ovr_q, ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (stat_rd) ovr_d = 1'b0;
    if (ovr_evt) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  always_comb begin
    stat    = '0;
    stat[0] = ~empty;
    stat[1] = ovr_q;
    stat[2] = ~empty & head_perr;
    stat[3] = ~empty & head_ferr;
    stat[4] = ~empty & head_brk;
    stat[7] = tagged_any;
  end

  // R4: a discard wins over a simultaneous status read
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_q);

  // R4: a status read without a new discard clears the flag
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !ovr_q);

  // R4: the flag rises only after a discard
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(ovr_evt));

endmodule

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       rx_line,
  input  logic       queue_mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       data_rd,
  input  logic       stat_rd,
  output logic [7:0] rd_data,
  output logic [7:0] line_stat
);

  logic       rs1_q, rs2_q, rst_n_i;
  logic       done, empty, tagged_any, ovr_evt;
  srx_entry_t ent, head;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_n_i = rs2_q;

  srx_deser #(.OSR(OSR)) u_deser (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .tick    (sample_en),
    .rx_raw  (rx_line),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (done),
    .ent     (ent)
  );

  srx_tagq #(.DEPTH(DEPTH)) u_q (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .queue_mode (queue_mode),
    .push       (done),
    .push_ent   (ent),
    .pop_req    (data_rd),
    .head       (head),
    .empty      (empty),
    .tagged_any (tagged_any),
    .ovr_evt    (ovr_evt)
  );

  srx_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .ovr_evt    (ovr_evt),
    .stat_rd    (stat_rd),
    .empty      (empty),
    .head_perr  (head.perr),
    .head_ferr  (head.ferr),
    .head_brk   (head.brk),
    .tagged_any (tagged_any),
    .stat       (line_stat)
  );

  assign rd_data = empty ? '0 : head.data;

  // R1: nothing is reported ready while the store is empty
  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    empty |-> (rd_data == '0 && line_stat[4:2] == '0));

endmodule

// File: tb/sim_serial_rx_tagq.sv
`timescale 1ns/1ps
module sim_serial_rx_tagq;

  logic       clk = 1'b0;
  logic       rst_n, sample_en, rx_line, queue_mode, par_en, par_odd;
  logic       data_rd, stat_rd;
  logic [7:0] rd_data, line_stat;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] d;
    logic       p, f, b;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  serial_rx_tagq u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_line(rx_line),
    .queue_mode(queue_mode), .par_en(par_en), .par_odd(par_odd),
    .data_rd(data_rd), .stat_rd(stat_rd), .rd_data(rd_data), .line_stat(line_stat)
  );

  // sample pulse every 4 clocks: one bit = 64 clocks
  initial begin
    int c;
    c = 0;
    sample_en = 1'b0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 4;
      sample_en = (c == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bit_time(input logic v);
    rx_line = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_v);
    bit_time(1'b0);
    for (int i = 0; i < 8; i++) bit_time(d[i]);
    if (par_en) bit_time((^d) ^ par_odd ^ bad_par);
    bit_time(stop_v);
    bit_time(1'b1);
  endtask

  // driver: sends a frame and records what must come out
  task automatic drive_char(input logic [7:0] d, input logic bad_par, input logic stop_v);
    exp_t e;
    send_frame(d, bad_par, stop_v);
    e.d = d;
    e.p = par_en & bad_par;
    e.f = ~stop_v;
    e.b = 1'b0;
    exp_q.push_back(e);
  endtask

  // monitor: compares the head against the scoreboard, then pops it
  task automatic pop_cmp(input string tag);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk({tag, " scoreboard empty"}, 32'd0, 32'd1);
      return;
    end
    e = exp_q.pop_front();
    chk({tag, " data"}, {24'd0, rd_data}, {24'd0, e.d});
    chk({tag, " tags"}, {29'd0, line_stat[4:2]}, {29'd0, e.b, e.f, e.p});
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_stat(output logic [7:0] v);
    v = line_stat;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] sv;
    logic       seen;
    exp_t       e;
    rst_n = 1'b0; rx_line = 1'b1; queue_mode = 1'b1; par_en = 1'b0;
    par_odd = 1'b0; data_rd = 1'b0; stat_rd = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 status", {24'd0, line_stat}, 32'h00);
    chk("R1 data", {24'd0, rd_data}, 32'h00);

    // R2 single character
    drive_char(8'hA5, 1'b0, 1'b1);
    chk("R2 ready", {24'd0, line_stat}, 32'h01);
    pop_cmp("R2 pop");
    chk("R2 drained", {24'd0, line_stat}, 32'h00);

    // R11 pop on empty, then normal use
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
    chk("R11 empty pop", {24'd0, line_stat}, 32'h00);
    drive_char(8'h3C, 1'b0, 1'b1);
    chk("R11 no underflow", {24'd0, line_stat}, 32'h01);
    pop_cmp("R11 after empty pop");

    // R3 ordering over several patterns
    drive_char(8'h00, 1'b0, 1'b1);
    drive_char(8'hFF, 1'b0, 1'b1);
    drive_char(8'h81, 1'b0, 1'b1);
    pop_cmp("R3 order0");
    pop_cmp("R3 order1");
    pop_cmp("R3 order2");

    // R4 fill, discard the seventeenth
    for (int i = 0; i < 16; i++) drive_char(8'(i * 13 + 7), 1'b0, 1'b1);
    send_frame(8'hEE, 1'b0, 1'b1);
    read_stat(sv);
    chk("R4 overrun seen", {24'd0, sv}, 32'h03);
    chk("R4 overrun cleared", {24'd0, line_stat}, 32'h01);
    for (int i = 0; i < 16; i++) pop_cmp("R4 intact");
    chk("R3 full drain", {24'd0, line_stat}, 32'h00);

    // R4 discard and status read in the same cycle
    for (int i = 0; i < 16; i++) drive_char(8'(255 - i), 1'b0, 1'b1);
    seen = 1'b0;
    fork
      send_frame(8'h55, 1'b0, 1'b1);
      begin
        for (int k = 0; k < 800 && !seen; k++) begin
          stat_rd = 1'b1;
          @(negedge clk);
          if (line_stat[1]) seen = 1'b1;
        end
        stat_rd = 1'b0;
      end
    join
    @(negedge clk);
    chk("R4 set wins", {31'd0, line_stat[1]}, 32'd1);
    for (int i = 0; i < 16; i++) pop_cmp("R4 same-cycle intact");
    read_stat(sv);
    chk("R4 final clear", {24'd0, line_stat}, 32'h00);

    // R5 parity, even then odd
    par_en = 1'b1; par_odd = 1'b0;
    drive_char(8'h17, 1'b0, 1'b1);
    drive_char(8'h17, 1'b1, 1'b1);
    chk("R8 summary behind clean head", {24'd0, line_stat}, 32'h81);
    pop_cmp("R5 good even");
    chk("R5 head parity", {24'd0, line_stat}, 32'h85);
    pop_cmp("R5 bad even");
    chk("R8 summary cleared", {24'd0, line_stat}, 32'h00);
    par_odd = 1'b1;
    drive_char(8'hC3, 1'b1, 1'b1);
    drive_char(8'hC3, 1'b0, 1'b1);
    chk("R5 odd bad head", {24'd0, line_stat}, 32'h85);
    pop_cmp("R5 bad odd");
    chk("R8 clean after tagged", {24'd0, line_stat}, 32'h01);
    pop_cmp("R5 good odd");
    par_en = 1'b0; par_odd = 1'b0;

    // R6 framing
    drive_char(8'h5A, 1'b0, 1'b0);
    chk("R6 framing", {24'd0, line_stat}, 32'h89);
    pop_cmp("R6 pop");

    // R7 long break
    repeat (30) bit_time(1'b0);
    bit_time(1'b1); bit_time(1'b1);
    e.d = 8'h00; e.p = 1'b0; e.f = 1'b0; e.b = 1'b1;
    exp_q.push_back(e);
    chk("R7 break status", {24'd0, line_stat}, 32'h91);
    pop_cmp("R7 break entry");
    chk("R7 single entry", {24'd0, line_stat}, 32'h00);

    // R10 short glitch
    rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (800) @(negedge clk);
    chk("R10 glitch ignored", {24'd0, line_stat}, 32'h00);

    // R9 single holding register
    queue_mode = 1'b0;
    @(negedge clk);
    drive_char(8'h96, 1'b0, 1'b1);
    send_frame(8'h69, 1'b0, 1'b1);
    chk("R9 overrun", {24'd0, line_stat}, 32'h03);
    pop_cmp("R9 first kept");
    chk("R9 only one held", {24'd0, line_stat}, 32'h02);
    read_stat(sv);
    chk("R9 cleared", {24'd0, line_stat}, 32'h00);
    chk("R11 bits 5 and 6", {30'd0, line_stat[6:5]}, 32'd0);

    summary();
  end

endmodule